// File: doc/BRIEF.md
# Interrupt Routing Mode Latch

This block watches configuration-space writes that a host bridge passes on and, once per reset, works out which interrupt routing the software expects. Before software commits, the block reports the correct routing. The first time software programs the interrupt-line register of a slot where the legacy wiring and the correct wiring disagree, the value written shows which routing it expects. The data value 27 selects the legacy routing, and any other value selects the correct routing. The choice is then frozen until the next reset.

The two-bit mode output drives an interrupt router that sits outside this block. A one-cycle lock strobe marks the moment the mode is frozen. On the alternative board family the strap input turns detection off, so the mode stays at its reset value.

Top module: `irqmode_latch`

## Requirements
- R1: The mode encoding is 2'b00 for assume-correct, 2'b01 for legacy and 2'b10 for forced-correct. Reset (synchronous, active high) sets the mode to 2'b00 and the lock strobe to 0.
- R2: Once the mode has left 2'b00, it does not change until the next reset, whatever writes arrive.
- R3: A write whose address bits [7:0] differ from 8'h3C leaves the mode unchanged.
- R4: The slot number is address bits [15:11]. A write to a slot where slot mod 4 equals 2 leaves the mode unchanged.
- R5: A qualifying write (offset 8'h3C, slot mod 4 not 2, mode 2'b00, strap low) whose data bits [7:0] equal 27 sets the mode to 2'b01 at the next clock edge. Data bits above bit 7 are ignored.
- R6: A qualifying write with any other value in data bits [7:0] sets the mode to 2'b10 at the next clock edge.
- R7: While the strap input `alt_board` is high, no write changes the mode.
- R8: The lock strobe is high for exactly one cycle, the same cycle in which the mode first shows a value other than 2'b00. It stays low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | Config write strobe, one write per high cycle |
| cfg_addr | input | 16 | Config address: devfn in [15:8], register offset in [7:0] |
| cfg_wdata | input | 32 | Config write data |
| alt_board | input | 1 | Board-family strap; high disables detection |
| route_mode | output | 2 | Registered routing mode for the interrupt router |
| mode_locked | output | 1 | One-cycle strobe when the mode is frozen |

## Verification
The bench builds the block with its default parameters: a 16-bit address, 32-bit data, four interrupt pins and offset 8'h3C. This makes complete sweeps practical. The bench tests every offset byte, every one of the 32 slots with both the magic value and a non-magic value, and every data low byte. Each case starts from a fresh reset, and the expected mode is computed from slot arithmetic. Separate cases cover writes after the lock, writes while the strap is high, and the width of the lock strobe.

// File: rtl/irqmode_pkg.sv
package irqmode_pkg;
  typedef enum logic [1:0] {
    MODE_ASSUME = 2'b00,
    MODE_LEGACY = 2'b01,
    MODE_FORCED = 2'b10
  } route_mode_e;
endpackage

// File: rtl/irqmode_snoop.sv
module irqmode_snoop #(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 32,
  parameter int          PIN_COUNT = 4,
  parameter int          SKIP_RES  = 2,
  parameter logic [7:0]  LINE_OFS  = 8'h3C,
  parameter logic [7:0]  MAGIC     = 8'd27
) (
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              hit,
  output logic              magic
);
  localparam int SLOT_LSB = 11;
  localparam int SLOT_W   = ADDR_W - SLOT_LSB;

  logic [SLOT_W-1:0] slot;
  logic [2:0]        unused_func;
  logic [DATA_W-9:0] unused_hi;
  logic              agree_slot;

  assign slot        = addr[ADDR_W-1:SLOT_LSB];
  assign unused_func = addr[SLOT_LSB-1:8];
  assign unused_hi   = wdata[DATA_W-1:8];
  assign agree_slot  = (int'(slot) % PIN_COUNT) == SKIP_RES;
  assign hit         = wr && (addr[7:0] == LINE_OFS) && !agree_slot;
  assign magic       = (wdata[7:0] == MAGIC);
endmodule

// File: rtl/irqmode_fsm.sv
module irqmode_fsm
  import irqmode_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        enable,
  input  logic        hit,
  input  logic        magic,
  output route_mode_e mode,
  output logic        lock
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= MODE_ASSUME;
      lock <= 1'b0;
    end else begin
      lock <= 1'b0;
      if (mode == MODE_ASSUME && enable && hit) begin
        mode <= magic ? MODE_LEGACY : MODE_FORCED;
        lock <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/irqmode_latch.sv
module irqmode_latch #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int PIN_COUNT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              alt_board,
  output logic [1:0]        route_mode,
  output logic              mode_locked
);
  import irqmode_pkg::*;

  logic        hit, magic;
  route_mode_e mode;

  irqmode_snoop #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PIN_COUNT(PIN_COUNT)
  ) snoop_i (
    .wr(cfg_wr), .addr(cfg_addr), .wdata(cfg_wdata),
    .hit(hit), .magic(magic)
  );

  irqmode_fsm fsm_i (
    .clk(clk), .rst(rst), .enable(!alt_board),
    .hit(hit), .magic(magic), .mode(mode), .lock(mode_locked)
  );

  assign route_mode = mode;
endmodule

// File: rtl/irqmode_latch_chk.sv
module irqmode_latch_chk (
  input logic        clk,
  input logic        rst,
  input logic        cfg_wr,
  input logic [15:0] cfg_addr,
  input logic        alt_board,
  input logic [1:0]  route_mode,
  input logic        mode_locked
);
  a_r1_legal_code: assert property (@(posedge clk) disable iff (rst)
    route_mode != 2'b11);
  a_r2_sticky: assert property (@(posedge clk) disable iff (rst)
    (route_mode != 2'b00) |=> $stable(route_mode));
  a_r3_other_offset: assert property (@(posedge clk) disable iff (rst)
    (route_mode == 2'b00 && (!cfg_wr || cfg_addr[7:0] != 8'h3C)) |=> route_mode == 2'b00);
  a_r4_agree_slot: assert property (@(posedge clk) disable iff (rst)
    (route_mode == 2'b00 && cfg_addr[12:11] == 2'd2) |=> route_mode == 2'b00);
  a_r7_strap: assert property (@(posedge clk) disable iff (rst)
    (route_mode == 2'b00 && alt_board) |=> route_mode == 2'b00);
  a_r8_lock_edge: assert property (@(posedge clk) disable iff (rst)
    mode_locked |-> ($past(route_mode) == 2'b00 && route_mode != 2'b00));
  a_r8_lock_single: assert property (@(posedge clk) disable iff (rst)
    mode_locked |=> !mode_locked);
endmodule

bind irqmode_latch irqmode_latch_chk chk_i (
  .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
  .alt_board(alt_board), .route_mode(route_mode), .mode_locked(mode_locked)
);

// File: tb/irqmode_latch_tb_top.sv
`timescale 1ns/1ps
module irqmode_latch_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [15:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        alt_board = 1'b0;
  logic [1:0]  route_mode;
  logic        mode_locked;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irqmode_latch dut_i (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .alt_board(alt_board),
    .route_mode(route_mode), .mode_locked(mode_locked)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    cfg_wr = 1'b0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  // drive one write; returns sampled just after the capturing edge
  task automatic cfg_write(logic [4:0] slot, logic [7:0] ofs, logic [31:0] d,
                           output logic [1:0] m, output logic l);
    @(negedge clk);
    cfg_wr = 1'b1;
    cfg_addr = {slot, 3'd0, ofs};
    cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
    m = route_mode;
    l = mode_locked;
  endtask

  function automatic logic [1:0] expect_mode(logic [4:0] slot, logic [7:0] ofs,
                                             logic [7:0] dlo);
    if (ofs != 8'h3C || (slot % 4) == 2) return 2'b00;
    return (dlo == 8'd27) ? 2'b01 : 2'b10;
  endfunction

  initial begin
    logic [1:0] m;
    logic       l;
    do_reset();
    check("R1 reset mode", route_mode, 2'b00);
    check("R1 reset lock", mode_locked, 1'b0);

    // R3: sweep all offsets on a disagreeing slot
    for (int o = 0; o < 256; o++) begin
      do_reset();
      cfg_write(5'd11, o[7:0], 32'd27, m, l);
      check("R3 offset sweep", m, expect_mode(5'd11, o[7:0], 8'd27));
    end
    // R4 R5 R6: all slots, magic and non-magic
    for (int s = 0; s < 32; s++) begin
      for (int k = 0; k < 2; k++) begin
        logic [7:0] d = (k == 0) ? 8'd27 : 8'd9;
        do_reset();
        cfg_write(s[4:0], 8'h3C, {24'h0, d}, m, l);
        check("R4/R5/R6 slot sweep", m, expect_mode(s[4:0], 8'h3C, d));
        check("R8 lock with slot", l, expect_mode(s[4:0], 8'h3C, d) != 2'b00);
      end
    end
    // R5 R6: all data low bytes, upper bits set
    for (int v = 0; v < 256; v++) begin
      do_reset();
      cfg_write(5'd31, 8'h3C, {24'hABCDEF, v[7:0]}, m, l);
      check("R5/R6 data sweep", m, (v == 27) ? 2'b01 : 2'b10);
    end
    // R2: later writes ignored
    do_reset();
    cfg_write(5'd12, 8'h3C, 32'd27, m, l);
    check("R5 first lock", m, 2'b01);
    cfg_write(5'd12, 8'h3C, 32'd5, m, l);
    check("R2 stays legacy", m, 2'b01);
    check("R8 no second pulse", l, 1'b0);
    do_reset();
    cfg_write(5'd13, 8'h3C, 32'd4, m, l);
    cfg_write(5'd13, 8'h3C, 32'd27, m, l);
    check("R2 stays forced", m, 2'b10);
    // R8: pulse lasts one cycle
    do_reset();
    cfg_write(5'd8, 8'h3C, 32'd1, m, l);
    check("R8 pulse high", l, 1'b1);
    @(negedge clk);
    check("R8 pulse gone", mode_locked, 1'b0);
    check("R8 mode held", route_mode, 2'b10);
    // R7: strap disables
    do_reset();
    alt_board = 1'b1;
    cfg_write(5'd11, 8'h3C, 32'd27, m, l);
    check("R7 strap legacy data", m, 2'b00);
    cfg_write(5'd11, 8'h3C, 32'd3, m, l);
    check("R7 strap other data", m, 2'b00);
    check("R7 strap no lock", l, 1'b0);
    alt_board = 1'b0;
    cfg_write(5'd11, 8'h3C, 32'd3, m, l);
    check("R7 strap released", m, 2'b10);
    // reset clears locked state
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset after lock", route_mode, 2'b00);
    rst = 1'b0;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual timeout expected completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule